// File: doc/BRIEF.md
# Prescaled Reloading Real-Time Counter

This block is an always-on interval timer. It keeps counting while the rest of the system is powered down, and it produces an interrupt request or a wake-up request at a programmable rate. The count chain is 23 bits long. A 7-bit prescaler divides the selected source, and each time the prescaler wraps, a 16-bit down counter takes one step. When the whole chain sits at zero, the next source tick reloads the counter from a software-written reload register and sets a sticky event flag. The interval is therefore (reload + 1) × 128 source ticks.

The block runs on one always-on clock. Its two possible time bases arrive as single-cycle tick strobes: one from the CPU clock and one from the crystal oscillator. Software selects the crystal base with a control bit. That selection is overridden, and the CPU-clock strobe is used, whenever the crystal is the clock that drives the CPU. The block has its own power-on reset. The ordinary system reset has no effect on it, so the counter survives system resets.

The control state machine has two states. ST_OFF holds the chain frozen; a reload write in ST_OFF preloads the counter and the prescaler. ST_RUN counts selected ticks. A control write with the run bit set moves the machine OFF→RUN (transition "start"). A control write with the run bit clear moves it RUN→OFF (transition "stop"). Any other control write keeps the current state.

Top module: `rtc_tick_timer`

## Requirements
- R1: While `por_n` is low, and directly after it rises, `count_o` is 0, `flag_o`, `irq_o` and `wake_o` are 0, the reload register is 0, the prescaler is at 127 and the machine is in ST_OFF.
- R2: In ST_RUN the 16-bit counter takes one down step for every 128 selected ticks. Fewer than 128 ticks since the last step leave `count_o` unchanged.
- R3: A selected tick that finds both counter and prescaler at zero reloads the counter from the reload register, sets the prescaler to 127 and sets the flag. One interval lasts (reload+1)×128 ticks.
- R4: The flag stays set until `flag_clr` is pulsed. A clear in the same cycle as a reload event leaves the flag set.
- R5: `irq_o` equals the flag AND control bit 2 (interrupt enable). `wake_o` equals the flag AND control bit 3 (wake enable).
- R6: Control bit 1 = 0 selects `cpu_tick` and bit 1 = 1 selects `xtal_tick`. While `xtal_is_cpu` is high, `cpu_tick` is used regardless of bit 1, and the unselected strobe has no effect.
- R7: A reload write in ST_OFF loads the counter with the written value and the prescaler with 127. In ST_RUN it only updates the reload register, which takes effect at the next reload event.
- R8: In ST_OFF, tick strobes change neither `count_o` nor the prescaler.
- R9: `sys_rst_n` has no effect on the counter, the prescaler, the flag or the configuration.
- R10: A control write (`ctl_we`) with bit 0 set enters ST_RUN, and one with bit 0 clear enters ST_OFF. Bits 1 to 3 are captured on every control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | Ordinary system reset; ignored by this block |
| cpu_tick | input | 1 | One-cycle strobe per CPU-clock source period |
| xtal_tick | input | 1 | One-cycle strobe per crystal source period |
| xtal_is_cpu | input | 1 | High when the crystal is the CPU clock |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Bit0 run, bit1 crystal select, bit2 irq enable, bit3 wake enable |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 16 | Reload value |
| flag_clr | input | 1 | Pulse to clear the event flag |
| count_o | output | 16 | Current down-counter value |
| flag_o | output | 1 | Sticky reload-event flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The hardest case to reach is a flag clear that lands in the very cycle of a reload event. To get there, the bench first lets one full interval expire so the flag is set. It then applies exactly one tick short of a second interval and drives the final tick and `flag_clr` on the same edge. The clock-source override is also hard to reach, because it needs the crystal selected while the counter sits mid-prescale. Strobes on each source are applied in 128-tick blocks with `xtal_is_cpu` in both states, and the step of `count_o` shows which source counted. The prescaler's survival across a system reset is checked by splitting a 128-tick block around the reset pulse.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } rtc_state_e;

    localparam int CTL_W    = 4;
    localparam int CTL_RUN  = 0;
    localparam int CTL_XTAL = 1;
    localparam int CTL_IRQ  = 2;
    localparam int CTL_WAKE = 3;
endpackage

// File: rtl/rtc_src_sel.sv
module rtc_src_sel (
    input  logic clk,
    input  logic por_n,
    input  logic sel_xtal,
    input  logic xtal_is_cpu,
    input  logic cpu_tick,
    input  logic xtal_tick,
    output logic tick_o
);
    logic use_xtal;

    // The crystal may only be used when it is not already the CPU clock.
    always_comb begin
        use_xtal = sel_xtal && !xtal_is_cpu;
        tick_o   = use_xtal ? xtal_tick : cpu_tick;
    end

    // R6
    fallback_cpu_chk: assert property (@(posedge clk) disable iff (!por_n)
        xtal_is_cpu |-> (tick_o == cpu_tick));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic tick,
    input  logic load,
    output logic wrap_o
);
    localparam logic [PRE_W-1:0] PRE_TOP = '1;

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre_q <= PRE_TOP;
        end else if (load) begin
            pre_q <= PRE_TOP;
        end else if (run && tick) begin
            pre_q <= pre_q - 1'b1;
        end
    end

    assign wrap_o = run && tick && (pre_q == '0);

    // R8
    pre_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!run && !load) |=> $stable(pre_q));
endmodule

// File: rtl/rtc_downcnt.sv
module rtc_downcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             step,
    input  logic             direct_load,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             underflow_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            reload_q <= '0;
        end else if (reload_we) begin
            reload_q <= reload_wdata;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (direct_load) begin
            cnt_q <= reload_wdata;
        end else if (step) begin
            cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
        end
    end

    assign cnt_o       = cnt_q;
    assign underflow_o = step && (cnt_q == '0);

    // R2
    step_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(cnt_q) |-> $past(step || direct_load));

    // R3
    reload_value_chk: assert property (@(posedge clk) disable iff (!por_n)
        underflow_o |=> (cnt_q == $past(reload_q)));
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
    import rtc_pkg::*;
#(
    parameter int PRE_W = 7,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             cpu_tick,
    input  logic             xtal_tick,
    input  logic             xtal_is_cpu,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             wake_o
);
    rtc_state_e state_q, state_d;
    logic       sel_xtal_q, irq_en_q, wake_en_q;
    logic       flag_q;
    logic       running, direct_load, tick_sel, wrap, underflow;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision: start / stop on control writes
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (ctl_we &&  ctl_wdata[CTL_RUN]) state_d = ST_RUN;
            ST_RUN: if (ctl_we && !ctl_wdata[CTL_RUN]) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // State-derived controls
    always_comb begin
        running     = 1'b0;
        direct_load = 1'b0;
        unique case (state_q)
            ST_OFF: direct_load = reload_we;
            ST_RUN: running     = 1'b1;
            default: running    = 1'b0;
        endcase
    end

    // Configuration bits
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sel_xtal_q <= 1'b0;
            irq_en_q   <= 1'b0;
            wake_en_q  <= 1'b0;
        end else if (ctl_we) begin
            sel_xtal_q <= ctl_wdata[CTL_XTAL];
            irq_en_q   <= ctl_wdata[CTL_IRQ];
            wake_en_q  <= ctl_wdata[CTL_WAKE];
        end
    end

    rtc_src_sel u_src (
        .clk         (clk),
        .por_n       (por_n),
        .sel_xtal    (sel_xtal_q),
        .xtal_is_cpu (xtal_is_cpu),
        .cpu_tick    (cpu_tick),
        .xtal_tick   (xtal_tick),
        .tick_o      (tick_sel)
    );

    rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .por_n  (por_n),
        .run    (running),
        .tick   (tick_sel),
        .load   (direct_load),
        .wrap_o (wrap)
    );

    rtc_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .por_n        (por_n),
        .step         (wrap),
        .direct_load  (direct_load),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .cnt_o        (count_o),
        .underflow_o  (underflow)
    );

    // Event flag: a reload event wins over a clear
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (underflow) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        flag_o = flag_q;
        irq_o  = flag_q && irq_en_q;
        wake_o = flag_q && wake_en_q;
    end

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (flag_q && !flag_clr) |=> flag_q);

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        underflow |=> flag_q);

    // R8
    off_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_OFF && !reload_we) |=> $stable(count_o));

    // R10
    start_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ctl_we && ctl_wdata[CTL_RUN]) |=> (state_q == ST_RUN));

    // R9
    sysrst_ignore_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && flag_q && !flag_clr) |=> flag_o);
endmodule

// File: tb/rtc_tick_timer_tb.sv
module rtc_tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        cpu_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        xtal_is_cpu = 1'b0;
    logic        ctl_we = 1'b0;
    logic [3:0]  ctl_wdata = 4'd0;
    logic        reload_we = 1'b0;
    logic [15:0] reload_wdata = 16'd0;
    logic        flag_clr = 1'b0;
    logic [15:0] count_o;
    logic        flag_o, irq_o, wake_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_tick_timer dut_i (
        .clk          (clk),
        .por_n        (por_n),
        .sys_rst_n    (sys_rst_n),
        .cpu_tick     (cpu_tick),
        .xtal_tick    (xtal_tick),
        .xtal_is_cpu  (xtal_is_cpu),
        .ctl_we       (ctl_we),
        .ctl_wdata    (ctl_wdata),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .flag_clr     (flag_clr),
        .count_o      (count_o),
        .flag_o       (flag_o),
        .irq_o        (irq_o),
        .wake_o       (wake_o)
    );

    // {reload, ticks, expected count, expected flag}
    localparam logic [48:0] VEC [0:7] = '{
        {16'd5, 16'd0,   16'd5, 1'b0},
        {16'd5, 16'd127, 16'd5, 1'b0},
        {16'd5, 16'd128, 16'd4, 1'b0},
        {16'd5, 16'd768, 16'd5, 1'b1},
        {16'd0, 16'd128, 16'd0, 1'b1},
        {16'd0, 16'd127, 16'd0, 1'b0},
        {16'd3, 16'd300, 16'd1, 1'b0},
        {16'd2, 16'd384, 16'd2, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ctl(input logic [3:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic reload(input logic [15:0] v);
        reload_we = 1'b1; reload_wdata = v;
        @(negedge clk);
        reload_we = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic ticks(input int n, input bit on_xtal);
        if (n > 0) begin
            if (on_xtal) xtal_tick = 1'b1; else cpu_tick = 1'b1;
            repeat (n) @(negedge clk);
            xtal_tick = 1'b0; cpu_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 state during reset
        check("R1 count in reset", count_o, 0);
        check("R1 flag in reset", flag_o, 0);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 count after reset", count_o, 0);
        check("R1 irq/wake after reset", {irq_o, wake_o}, 0);

        // Vector table: R2 prescale, R3 reload, R7 load-while-off, R10 start/stop
        foreach (VEC[i]) begin
            ctl(4'b0000);
            clear_flag();
            reload(VEC[i][48:33]);
            ctl(4'b0001);
            ticks(int'(VEC[i][32:17]), 1'b0);
            check($sformatf("R2/R3/R7 vec%0d count", i), count_o, int'(VEC[i][16:1]));
            check($sformatf("R3/R4 vec%0d flag", i), flag_o, int'(VEC[i][0]));
        end

        // R4: clear coinciding with reload event keeps flag
        ctl(4'b0000);
        clear_flag();
        reload(16'd0);
        ctl(4'b0001);
        ticks(128, 1'b0);
        check("R4 flag set", flag_o, 1);
        ticks(127, 1'b0);
        cpu_tick = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        cpu_tick = 1'b0; flag_clr = 1'b0;
        check("R4 clear vs event", flag_o, 1);
        clear_flag();
        check("R4 clear alone", flag_o, 0);

        // R5: output gating
        ticks(128, 1'b0);
        check("R5 flag before gating", flag_o, 1);
        check("R5 both disabled", {irq_o, wake_o}, 0);
        ctl(4'b0101);
        check("R5 irq only", {irq_o, wake_o}, 2);
        ctl(4'b1001);
        check("R5 wake only", {irq_o, wake_o}, 1);
        clear_flag();
        check("R5 cleared", {irq_o, wake_o}, 0);

        // R6: source selection and fallback
        ctl(4'b0000);
        reload(16'd2);
        ctl(4'b0011);
        ticks(128, 1'b0);
        check("R6 cpu ignored when xtal selected", count_o, 2);
        ticks(128, 1'b1);
        check("R6 xtal counts", count_o, 1);
        xtal_is_cpu = 1'b1;
        ticks(128, 1'b1);
        check("R6 xtal ignored on fallback", count_o, 1);
        ticks(128, 1'b0);
        check("R6 cpu counts on fallback", count_o, 0);
        xtal_is_cpu = 1'b0;

        // R7: reload write while running
        ctl(4'b0001);
        reload(16'd9);
        check("R7 running write no load", count_o, 0);
        clear_flag();
        ticks(128, 1'b0);
        check("R7 new reload used", count_o, 9);
        check("R7 event flag", flag_o, 1);

        // R8 / R10: stop freezes the chain
        ctl(4'b0000);
        ticks(300, 1'b0);
        check("R8 off count frozen", count_o, 9);

        // R9: system reset ignored, prescaler kept
        ctl(4'b0001);
        ticks(50, 1'b0);
        sys_rst_n = 1'b0;
        repeat (5) @(negedge clk);
        sys_rst_n = 1'b1;
        check("R9 count kept", count_o, 9);
        check("R9 flag kept", flag_o, 1);
        ticks(78, 1'b0);
        check("R9 prescaler kept", count_o, 8);

        // R1: power-on reset mid-run
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 por count", count_o, 0);
        check("R1 por flag", flag_o, 0);
        ticks(200, 1'b0);
        check("R1 por leaves block off", count_o, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule